// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block sits between the 8b/10b encoders and the serializers of a four-lane serial link. In normal operation it passes each lane's 10-bit encoded symbol through one register stage. When test mode is on, it drops the live data and drives every lane with the same repeating compliance pattern, one 10-bit symbol per lane per clock. The pattern is chosen by a 2-bit select field.

There are three patterns. The high-frequency pattern alternates single ones and zeros. The low-frequency pattern is runs of five ones and five zeros. The mixed-frequency pattern is a comma code group that alternates between its two running-disparity forms. The fourth select code is reserved, and the block maps it to the high-frequency pattern so that the link always carries a defined waveform.

The enable and select inputs normally come from a management register file, which resets the enable to 0. The output register is present in both modes. Entering or leaving test mode therefore never changes the pipeline depth.

Top module: `ltpg_top`

## Requirements
- R1: While `rst` is high, every lane output is all zeros. A new mixed-pattern run always starts with the negative-disparity form.
- R2: With `tp_en` low, each lane's output equals that lane's `enc_data` slice from the previous clock.
- R3: With `tp_en` high and `tp_sel` = 2'b00, every lane outputs 10'b1010101010 on the next clock. Bit 9 is the first bit serialized.
- R4: With `tp_en` high and `tp_sel` = 2'b01, every lane outputs 10'b1111100000 on the next clock.
- R5: With `tp_en` high and `tp_sel` = 2'b10, the lanes output 10'b0011111010 on the first clock of the run and 10'b1100000101 on the next. The two then alternate for as long as the selection holds. Any other mode in between restarts the run at 10'b0011111010.
- R6: With `tp_en` high and `tp_sel` = 2'b11, every lane outputs 10'b1010101010.
- R7: While test mode is enabled, all lanes carry the same symbol in the same cycle, whatever the `enc_data` contents.
- R8: Latency from the inputs to `ser_data` is exactly one clock in both modes. A change of `tp_en` or `tp_sel` shows on the very next output symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one 10-bit symbol per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tp_en | input | 1 | 1 = transmit test pattern, 0 = pass encoded data |
| tp_sel | input | 2 | Pattern select: 00 high, 01 low, 10 mixed, 11 reserved (high) |
| enc_data | input | LANES*10 (40) | Live encoded symbols; lane n occupies bits [10n+9:10n] |
| ser_data | output | LANES*10 (40) | Registered symbols toward the serializers, same lane layout |

## Verification
The bench builds the block with its default of four lanes. Four lanes are enough to show that all lanes receive the same pattern while each lane's live data stays separate in pass-through. The model follows every mode switch and every mixed-run restart at single-cycle resolution. It also drives random lane data during test mode, which shows that the live stream never leaks into the pattern.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;
  localparam int SYM_W = 10;

  typedef enum logic [1:0] {
    SEL_HIGH  = 2'b00,
    SEL_LOW   = 2'b01,
    SEL_MIXED = 2'b10,
    SEL_RSVD  = 2'b11
  } tp_sel_e;

  // bit 9 leaves the serializer first
  localparam logic [SYM_W-1:0] PAT_HIGH  = 10'b1010101010;
  localparam logic [SYM_W-1:0] PAT_LOW   = 10'b1111100000;
  localparam logic [SYM_W-1:0] PAT_MIX_N = 10'b0011111010;
  localparam logic [SYM_W-1:0] PAT_MIX_P = 10'b1100000101;
endpackage

// File: rtl/ltpg_pattern_src.sv
module ltpg_pattern_src
  import ltpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tp_en,
  input  logic [1:0]       tp_sel,
  output logic [SYM_W-1:0] pat_sym
);
  tp_sel_e sel_e;
  logic    mix_active;
  logic    phase_q;

  assign sel_e      = tp_sel_e'(tp_sel);
  assign mix_active = tp_en && (sel_e == SEL_MIXED);

  // disparity phase: runs only while mixed pattern is being sent
  always_ff @(posedge clk) begin
    if (rst)             phase_q <= 1'b0;
    else if (mix_active) phase_q <= ~phase_q;
    else                 phase_q <= 1'b0;
  end

  always_comb begin
    unique case (sel_e)
      SEL_LOW:   pat_sym = PAT_LOW;
      SEL_MIXED: pat_sym = phase_q ? PAT_MIX_P : PAT_MIX_N;
      default:   pat_sym = PAT_HIGH; // high and reserved
    endcase
  end

  // R1 / R5: a run entered from another mode starts on the negative form
  a_r5_run_start: assert property (@(posedge clk) disable iff (rst)
    (mix_active && !$past(mix_active)) |-> (pat_sym == PAT_MIX_N));
endmodule

// File: rtl/ltpg_lane_stage.sv
module ltpg_lane_stage #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_pat,
  input  logic [SYM_W-1:0] pat_sym,
  input  logic [SYM_W-1:0] live_sym,
  output logic [SYM_W-1:0] out_sym
);
  always_ff @(posedge clk) begin
    if (rst)          out_sym <= '0;
    else if (use_pat) out_sym <= pat_sym;
    else              out_sym <= live_sym;
  end

  // R2 / R8: pass-through is exactly one stage deep
  a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(use_pat)) |-> (out_sym == $past(live_sym)));
endmodule

// File: rtl/ltpg_top.sv
module ltpg_top
  import ltpg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tp_en,
  input  logic [1:0]             tp_sel,
  input  logic [LANES*SYM_W-1:0] enc_data,
  output logic [LANES*SYM_W-1:0] ser_data
);
  localparam int BUS_W = LANES * SYM_W;

  logic [SYM_W-1:0] pat_sym;

  ltpg_pattern_src u_src (
    .clk     (clk),
    .rst     (rst),
    .tp_en   (tp_en),
    .tp_sel  (tp_sel),
    .pat_sym (pat_sym)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ltpg_lane_stage #(.SYM_W(SYM_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .use_pat  (tp_en),
      .pat_sym  (pat_sym),
      .live_sym (enc_data[g*SYM_W +: SYM_W]),
      .out_sym  (ser_data[g*SYM_W +: SYM_W])
    );

    // R7: every lane matches lane 0 while a pattern is sent
    a_r7_lanes_equal: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(tp_en)) |->
        (ser_data[g*SYM_W +: SYM_W] == ser_data[SYM_W-1:0]));
  end

  logic [SYM_W-1:0] lane0;
  assign lane0 = ser_data[SYM_W-1:0];

  // R1: cleared output after a reset cycle
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (ser_data == {BUS_W{1'b0}}));

  a_r3_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tp_en) && $past(tp_sel) == 2'b00) |-> (lane0 == PAT_HIGH));

  a_r4_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tp_en) && $past(tp_sel) == 2'b01) |-> (lane0 == PAT_LOW));

  a_r6_reserved: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tp_en) && $past(tp_sel) == 2'b11) |-> (lane0 == PAT_HIGH));

  // R5: consecutive mixed symbols alternate
  a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) &&
     $past(tp_en) && $past(tp_sel) == 2'b10 &&
     $past(tp_en, 2) && $past(tp_sel, 2) == 2'b10) |-> (lane0 != $past(lane0)));
endmodule

// File: tb/sim_ltpg_top.sv
module sim_ltpg_top;
  localparam int LANES = 4;
  localparam int W     = 10;
  localparam int BW    = LANES * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tp_en = 1'b0;
  logic [1:0]    tp_sel = 2'b00;
  logic [BW-1:0] enc_data = '0;
  logic [BW-1:0] ser_data;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  ltpg_top #(.LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .tp_en(tp_en), .tp_sel(tp_sel),
    .enc_data(enc_data), .ser_data(ser_data)
  );

  // behavioural reference
  logic [BW-1:0] exp_q = '0;
  string         tag   = "R1";
  int            mix_n = 0;
  bit            prev_en = 1'b0;
  logic [1:0]    prev_sel = 2'b00;
  bit            live = 1'b0;

  function automatic logic [W-1:0] pat_of(input logic [1:0] s, input int n);
    case (s)
      2'b01:   return 10'b1111100000;
      2'b10:   return (n % 2 == 0) ? 10'b0011111010 : 10'b1100000101;
      default: return 10'b1010101010;
    endcase
  endfunction

  always @(posedge clk) begin
    live <= 1'b1;
    if (rst) begin
      exp_q <= '0; tag <= "R1"; mix_n = 0;
    end else if (!tp_en) begin
      exp_q <= enc_data;
      tag <= prev_en ? "R8 R2" : "R2";
      mix_n = 0;
    end else begin
      logic [W-1:0] s;
      s = pat_of(tp_sel, mix_n);
      exp_q <= {LANES{s}};
      case (tp_sel)
        2'b00: tag <= "R3 R7";
        2'b01: tag <= "R4 R7";
        2'b10: tag <= "R5 R7";
        default: tag <= "R6 R7";
      endcase
      if (!prev_en || prev_sel != tp_sel) tag <= "R8 R7";
      if (tp_sel == 2'b10) mix_n++; else mix_n = 0;
    end
    prev_en  <= tp_en;
    prev_sel <= tp_sel;
  end

  always @(negedge clk) begin
    if (live && !done) begin
      checks++;
      if (ser_data !== exp_q) begin
        bad++;
        $display("FAIL %s: ser_data=%h expected=%h", tag, ser_data, exp_q);
      end
    end
  end

  task automatic run(input bit en, input logic [1:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tp_en = en; tp_sel = s;
      enc_data = {$urandom, $urandom};
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk) rst = 1'b0;
    run(1'b0, 2'b00, 12);  // R2 pass-through, per-lane data
    run(1'b1, 2'b00, 6);   // R3
    run(1'b1, 2'b01, 6);   // R4
    run(1'b1, 2'b10, 9);   // R5 alternation
    run(1'b1, 2'b00, 1);   // interrupt run
    run(1'b1, 2'b10, 5);   // R5 restart on negative form
    run(1'b1, 2'b11, 6);   // R6 reserved code
    run(1'b0, 2'b10, 4);   // R8 leave test mode
    run(1'b1, 2'b10, 3);   // R8 re-enter
    run(1'b0, 2'b11, 6);   // R2 select ignored while off
    @(negedge clk) rst = 1'b1; // R1 mid-stream reset
    tp_en = 1'b1;
    run(1'b1, 2'b01, 2);
    @(negedge clk) rst = 1'b0;
    run(1'b1, 2'b10, 4);   // R1 fresh run after reset
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule